// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns a fast peripheral clock into two strobes for an asynchronous serial port: a sample strobe at the oversampling rate and a bit strobe at the line bit rate. The sample strobe comes from a 16-bit integer divisor assembled from two byte inputs. That divisor is stretched on average by a rational factor `1 + step/modulus`: a small accumulator occasionally lets an extra divisor period pass without a strobe. The bit strobe is then formed by counting sample strobes against an oversampling ratio that has an integer part and a fraction in eighths.

The average bit rate is `f_clk / (OSR * D * (1 + step/modulus))`, where `D = 256*div_hi + div_lo` and `OSR = os_int + 1 + os_frac/8`. The serializer, register decoding and rate detection live outside this block. It is driven from static configuration inputs. Any change to those inputs restarts every counter, so the new rate begins from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `bit_tick` are both 0.
- R2: With the fractional stage disabled, `sample_tick` is a one-cycle pulse that repeats every D clock cycles.
- R3: A divisor of 0 (both bytes zero) behaves as a divisor of 1, so `sample_tick` pulses every cycle.
- R4: The divisor is D = 256*`div_hi` + `div_lo`.
- R5: `frac_cfg[3:0]` is the step and `frac_cfg[7:4]` is the modulus. When 0 < step < modulus, each gap between sample pulses is D or 2D cycles, and any run of `modulus` consecutive gaps adds up to exactly D*(modulus+step) cycles.
- R6: A step of 0, a modulus of 0, or a step not below the modulus disables the fractional stage, and the block falls back to the plain integer divide of R2.
- R7: With `os_frac` = 0, `bit_tick` pulses on every (`os_int`+1)-th sample pulse, and every `bit_tick` pulse coincides with a `sample_tick` pulse.
- R8: With `os_frac` nonzero, each bit lasts `os_int`+1 or `os_int`+2 sample pulses, and any 8 consecutive bits add up to 8*(`os_int`+1)+`os_frac` sample pulses.
- R9: After any configuration input changes, the first `sample_tick` is seen D+1 rising edges after the change, no pulse is issued before it, and the bit count restarts, so the first `bit_tick` falls on the (`os_int`+1)-th sample pulse after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_lo | input | 8 | Low byte of the integer divisor |
| div_hi | input | 8 | High byte of the integer divisor |
| frac_cfg | input | 8 | Fractional stretch: [3:0] step, [7:4] modulus |
| os_int | input | 4 | Oversampling ratio integer part minus one |
| os_frac | input | 2 | Oversampling ratio fraction in eighths |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with a sample strobe |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a running period, while the stretch accumulator or the eighths accumulator holds a nonzero remainder. The ports show only the strobes, so a stale remainder would appear only as one wrong gap. The stimulus lets a stretched pattern run for several strobes and then changes the divisor on an arbitrary cycle. It counts edges to the first new strobe and checks that the bit count starts over. The fractional tests measure whole runs of `modulus` gaps and of eight bits rather than single gaps. A wrong accumulator therefore shows up as a wrong total even when each single gap still looks legal.

// File: rtl/frac_baud_pkg.sv
// Shared default widths for the fractional baud tick generator.
// Assumes: the divisor is built from two equal-width bytes.
package frac_baud_pkg;
    localparam int BAUD_BYTE_W   = 8;  // width of one divisor byte
    localparam int BAUD_FRAC_W   = 4;  // width of step and modulus fields
    localparam int BAUD_OSI_W    = 4;  // oversampling integer field
    localparam int BAUD_OSF_W    = 2;  // oversampling fraction field
    localparam int BAUD_EIGHTH_W = 3;  // eighths accumulator width
endpackage

// File: rtl/baud_cfg_track.sv
// Holds a registered copy of the raw configuration and flags any change.
// Assumes: the configuration is quasi-static. A change costs one restart.
module baud_cfg_track #(
    parameter int CFG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic             restart
);
    // Snapshot of the configuration seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_in;
    end

    // A difference between live and held configuration restarts all counters.
    always_comb restart = (cfg_in != cfg_q);
endmodule

// File: rtl/baud_cfg_decode.sv
// Turns the held configuration fields into effective divider controls.
// Assumes: out-of-range fractional pairs should degrade to integer divide.
module baud_cfg_decode #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic [DIV_W-1:0]  div_raw,
    input  logic [FRAC_W-1:0] step_raw,
    input  logic [FRAC_W-1:0] mod_raw,
    output logic [DIV_W-1:0]  div_eff,
    output logic              frac_en
);
    // A zero divisor is promoted to one.
    always_comb div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;

    // The stretch stage runs only for a nonzero step strictly below the modulus.
    always_comb frac_en = (step_raw != '0) && (step_raw < mod_raw);
endmodule

// File: rtl/baud_prescaler.sv
// Counts clock cycles into sample pulses. With the stretch stage enabled it
// accumulates the step modulo the modulus once per issued pulse and, on each
// wrap, lets one extra divisor period pass silently.
// Assumes: div_eff >= 1, and step < modulus whenever frac_en is high.
module baud_prescaler #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] step,
    input  logic [FRAC_W-1:0] modulus,
    output logic              tick
);
    localparam int SUM_W = FRAC_W + 1;

    logic [DIV_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              extra_q;
    logic              period_end;
    logic [SUM_W-1:0]  acc_sum;
    logic [SUM_W-1:0]  acc_less;
    logic              acc_wrap;

    // The final cycle of a divisor period.
    always_comb period_end = (cnt_q == (div_eff - DIV_W'(1)));

    // Add the step to the remainder and compare against the modulus.
    always_comb begin
        acc_sum  = {1'b0, acc_q} + {1'b0, step};
        acc_less = acc_sum - {1'b0, modulus};
        acc_wrap = (acc_sum >= {1'b0, modulus});
    end

    // A pulse ends every period that is not an inserted extra one.
    always_comb tick = period_end && !extra_q && !restart;

    // Period counter, stretch remainder and pending-extra flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (period_end) begin
            cnt_q <= '0;
            if (extra_q) begin
                extra_q <= 1'b0;
            end else if (frac_en) begin
                if (acc_wrap) begin
                    acc_q   <= acc_less[FRAC_W-1:0];
                    extra_q <= 1'b1;
                end else begin
                    acc_q <= acc_sum[FRAC_W-1:0];
                end
            end
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R5: the remainder always stays below the modulus while stretching.
    a_r5_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        frac_en |-> (acc_q < modulus));
    // R6: an extra period is only ever pending with the stretch stage on.
    a_r6_extra_needs_frac: assert property (@(posedge clk) disable iff (!rst_n)
        extra_q |-> frac_en);
    // R2: a pulse lasts one cycle unless the divisor is one.
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_eff != DIV_W'(1))) |=> !tick);
endmodule

// File: rtl/baud_oversampler.sv
// Counts sample pulses into bit pulses. The integer ratio comes from os_int+1.
// The eighths accumulator lengthens the next bit by one sample on each
// overflow.
// Assumes: sample_in is a single-cycle strobe.
module baud_oversampler #(
    parameter int OSI_W    = 4,
    parameter int OSF_W    = 2,
    parameter int EIGHTH_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             sample_in,
    input  logic [OSI_W-1:0] os_int,
    input  logic [OSF_W-1:0] os_frac,
    output logic             bit_pulse
);
    localparam int CNT_W = OSI_W + 1;
    localparam int FS_W  = EIGHTH_W + 1;

    logic [CNT_W-1:0]    scnt_q;
    logic [EIGHTH_W-1:0] facc_q;
    logic                long_q;
    logic [CNT_W-1:0]    last_idx;
    logic [FS_W-1:0]     fsum;

    // Index of the final sample in the current bit, one later for a long bit.
    always_comb last_idx = {1'b0, os_int} + CNT_W'(long_q);

    // Eighths remainder after this bit's fraction is added.
    always_comb fsum = {1'b0, facc_q} + FS_W'(os_frac);

    // A bit ends on the sample pulse that carries the last index.
    always_comb bit_pulse = sample_in && (scnt_q == last_idx);

    // Sample counter, eighths remainder and long-bit flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            scnt_q <= '0;
            facc_q <= '0;
            long_q <= 1'b0;
        end else if (sample_in) begin
            if (scnt_q == last_idx) begin
                scnt_q <= '0;
                facc_q <= fsum[EIGHTH_W-1:0];
                long_q <= fsum[EIGHTH_W];
            end else begin
                scnt_q <= scnt_q + CNT_W'(1);
            end
        end
    end

    // R7: the sample count never runs past the longest permitted bit.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        scnt_q <= ({1'b0, os_int} + CNT_W'(1)));
    // R8: a long bit is only scheduled when a fraction is programmed.
    a_r8_long_needs_frac: assert property (@(posedge clk) disable iff (!rst_n)
        long_q |-> (os_frac != '0));
endmodule

// File: rtl/frac_baud_gen.sv
// Top of the fractional baud tick generator. It tracks configuration changes,
// decodes the fields, divides the clock into sample pulses and counts those
// into bit pulses. Both strobes leave through registers.
// Assumes: the configuration inputs are synchronous to clk.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int BYTE_W   = BAUD_BYTE_W,
    parameter int FRAC_W   = BAUD_FRAC_W,
    parameter int OSI_W    = BAUD_OSI_W,
    parameter int OSF_W    = BAUD_OSF_W,
    parameter int EIGHTH_W = BAUD_EIGHTH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   div_lo,
    input  logic [BYTE_W-1:0]   div_hi,
    input  logic [2*FRAC_W-1:0] frac_cfg,
    input  logic [OSI_W-1:0]    os_int,
    input  logic [OSF_W-1:0]    os_frac,
    output logic                sample_tick,
    output logic                bit_tick
);
    localparam int DIV_W = 2 * BYTE_W;
    localparam int CFG_W = DIV_W + 2 * FRAC_W + OSI_W + OSF_W;

    logic [CFG_W-1:0]  cfg_live;
    logic [CFG_W-1:0]  cfg_q;
    logic              restart;
    logic [DIV_W-1:0]  div_raw;
    logic [FRAC_W-1:0] step_q;
    logic [FRAC_W-1:0] mod_q;
    logic [OSI_W-1:0]  osi_q;
    logic [OSF_W-1:0]  osf_q;
    logic [DIV_W-1:0]  div_eff;
    logic              frac_en;
    logic              sample_pulse;
    logic              bit_pulse;

    // Pack every configuration field so one compare covers them all.
    always_comb cfg_live = {div_hi, div_lo, frac_cfg, os_int, os_frac};

    // Unpack the held copy that drives the counters.
    always_comb {div_raw, mod_q, step_q, osi_q, osf_q} = cfg_q;

    baud_cfg_track #(.CFG_W(CFG_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_live),
        .cfg_q   (cfg_q),
        .restart (restart)
    );

    baud_cfg_decode #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_decode (
        .div_raw  (div_raw),
        .step_raw (step_q),
        .mod_raw  (mod_q),
        .div_eff  (div_eff),
        .frac_en  (frac_en)
    );

    baud_prescaler #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_eff (div_eff),
        .frac_en (frac_en),
        .step    (step_q),
        .modulus (mod_q),
        .tick    (sample_pulse)
    );

    baud_oversampler #(.OSI_W(OSI_W), .OSF_W(OSF_W), .EIGHTH_W(EIGHTH_W)) u_oversample (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .sample_in (sample_pulse),
        .os_int    (osi_q),
        .os_frac   (osf_q),
        .bit_pulse (bit_pulse)
    );

    // Register both strobes so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
        end else begin
            sample_tick <= sample_pulse;
            bit_tick    <= bit_pulse;
        end
    end

    // R7: a bit strobe never appears without a sample strobe.
    a_r7_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    // R9: the cycle after a configuration change carries no sample strobe.
    a_r9_quiet_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample_tick);
    // R1: both strobes are low in the cycle after a reset edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/100ps
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] frac_cfg = 8'd0;
    logic [3:0] os_int = 4'd15;
    logic [1:0] os_frac = 2'd0;
    logic       sample_tick;
    logic       bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .frac_cfg(frac_cfg), .os_int(os_int), .os_frac(os_frac),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int dv, input int fr, input int oi, input int of);
        @(negedge clk);
        div_hi   = 8'(dv >> 8);
        div_lo   = 8'(dv);
        frac_cfg = 8'(fr);
        os_int   = 4'(oi);
        os_frac  = 2'(of);
    endtask

    // Cycles (negedges) until the next sample strobe.
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick && n < 5000);
    endtask

    // Cycles (negedges) until the next bit strobe.
    task automatic next_bit(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 5000);
    endtask

    task automatic t_reset();
        int seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        chk(seen == 0, "R1 strobes in reset", seen, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_integer();
        int n;
        set_cfg(5, 8'h00, 15, 0);
        next_tick(n);
        for (int i = 0; i < 3; i++) begin
            next_tick(n);
            chk(n == 5, "R2 integer gap", n, 5);
        end
        @(negedge clk);
        chk(sample_tick == 1'b0, "R2 pulse width", int'(sample_tick), 0);
    endtask

    task automatic t_bytes();
        int n;
        set_cfg(259, 8'h00, 15, 0);
        next_tick(n);
        for (int i = 0; i < 2; i++) begin
            next_tick(n);
            chk(n == 259, "R4 two-byte divisor", n, 259);
        end
    endtask

    task automatic t_zero();
        int n;
        set_cfg(0, 8'h00, 15, 0);
        next_tick(n);
        for (int i = 0; i < 3; i++) begin
            next_tick(n);
            chk(n == 1, "R3 zero divisor", n, 1);
        end
    endtask

    task automatic t_frac(input int dv, input int step, input int md);
        int n;
        int sum = 0;
        int bad = 0;
        set_cfg(dv, (md << 4) | step, 15, 0);
        next_tick(n);
        next_tick(n);
        for (int i = 0; i < md; i++) begin
            next_tick(n);
            sum += n;
            if (n != dv && n != 2 * dv) bad++;
        end
        chk(bad == 0, "R5 stretched gap is D or 2D", bad, 0);
        chk(sum == dv * (md + step), "R5 run total", sum, dv * (md + step));
    endtask

    task automatic t_frac_off(input int fr);
        int n;
        int bad = 0;
        set_cfg(6, fr, 15, 0);
        next_tick(n);
        for (int i = 0; i < 8; i++) begin
            next_tick(n);
            if (n != 6) bad++;
        end
        chk(bad == 0, "R6 fraction disabled", bad, 0);
    endtask

    task automatic t_os_int(input int dv, input int oi);
        int n;
        int exp = dv * (oi + 1);
        set_cfg(dv, 8'h00, oi, 0);
        next_bit(n);
        for (int i = 0; i < 3; i++) begin
            next_bit(n);
            chk(n == exp, "R7 bit gap", n, exp);
            chk(sample_tick == 1'b1, "R7 bit on sample", int'(sample_tick), 1);
        end
    endtask

    task automatic t_os_frac(input int oi, input int of);
        int n;
        int sum = 0;
        int bad = 0;
        int exp = 8 * (oi + 1) + of;
        set_cfg(1, 8'h00, oi, of);
        next_bit(n);
        for (int i = 0; i < 8; i++) begin
            next_bit(n);
            sum += n;
            if (n != oi + 1 && n != oi + 2) bad++;
        end
        chk(bad == 0, "R8 bit length range", bad, 0);
        chk(sum == exp, "R8 eight-bit total", sum, exp);
    endtask

    task automatic t_restart();
        int n;
        set_cfg(7, 8'h31, 1, 1);
        for (int i = 0; i < 5; i++) next_tick(n);
        repeat (3) @(negedge clk);
        set_cfg(9, 8'h31, 1, 1);
        next_tick(n);
        chk(n == 10, "R9 first strobe after change", n, 10);
        chk(bit_tick == 1'b0, "R9 bit count restarted (first)", int'(bit_tick), 0);
        next_tick(n);
        chk(bit_tick == 1'b1, "R9 bit count restarted (second)", int'(bit_tick), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_integer();
        t_bytes();
        t_zero();
        t_frac(4, 3, 7);
        t_frac(3, 1, 2);
        t_frac_off(8'h35);
        t_frac_off(8'h05);
        t_frac_off(8'h70);
        t_os_int(1, 3);
        t_os_int(2, 2);
        t_os_frac(3, 3);
        t_os_frac(0, 1);
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule